// File: doc/BRIEF.md
# Pixel Word Serializer with Parity

This block turns one parallel video pixel word per pixel period into a single-wire serial stream. The parallel word is 24 colour bits plus vertical sync, horizontal sync and data-enable. On each selected edge of the pixel clock it captures the word into a holding register. At the next frame boundary it loads a 30-bit frame into a shift register. The frame is the 27 payload bits, two reserved zero bits and one odd-parity bit. It then sends the frame one bit per bit-clock cycle. The bit clock runs at thirty times the pixel rate and is an input. The block also sends a recreated pixel clock, which is the bit clock divided by thirty, and an output-enable flag that marks the stream as valid.

The pixel clock is treated as a slow signal and sampled in the bit-clock domain. A select pin picks the capture edge, rising or falling. A second select pin reverses the RGB input order so that board routing can be mirrored. A transmit-enable input starts and stops the stream. While it is low, both outputs are held at 0 and the bit counter is held at the first position.

Top module: `pix_ser_top`

## Requirements
- R1: With swapSel=0, frame bits 0..7 carry red[7] down to red[0], bits 8..15 carry green[7]..green[0], bits 16..23 carry blue[7]..blue[0], and bits 24, 25 and 26 carry vsync, hsync and de.
- R2: With swapSel=1, frame bits 0..7 carry blue[0] up to blue[7], bits 8..15 carry green[0]..green[7], bits 16..23 carry red[0]..red[7], and bits 24..26 carry vsync, hsync and de as with swapSel=0.
- R3: Frame bit 29 is the odd-parity bit over frame bits 0..26. It is 1 when those 27 bits hold an even number of ones and 0 otherwise, so that bits 0..26 and bit 29 together always hold an odd count of ones.
- R4: Frame bits 27 and 28 are always 0 and do not enter the parity.
- R5: serOut sends frame bit 0 first and one bit per bit-clock cycle. Bit 0 is on the wire in the first cycle in which clkOut is high.
- R6: clkOut has a period of 30 bit clocks: 15 cycles high, which are frame bits 0..14, followed by 15 cycles low.
- R7: With edgeSel=0 the word is captured on a rising pixClk edge, and falling edges are ignored. With edgeSel=1 it is captured on a falling edge, and rising edges are ignored.
- R8: A pixClk edge takes effect two bit-clock edges after it is seen. The captured word does not disturb a frame already being sent; it is sent in the first frame that starts after the capture.
- R9: One cycle after txEn is sampled low, outEn, clkOut and serOut are 0. They stay 0 for as long as txEn is low, whatever the data and pixClk inputs do.
- R10: One cycle after txEn is sampled high while the block is idle, outEn is 1 and clkOut is high, and serOut carries bit 0 of the frame built from the word held at that moment.
- R11: While rstN is low, outEn, clkOut and serOut are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, 30 times the pixel rate |
| rstN | input | 1 | Active-low reset |
| txEn | input | 1 | Transmit enable |
| pixClk | input | 1 | Pixel clock, sampled in the clk domain |
| edgeSel | input | 1 | Capture edge: 0 rising, 1 falling |
| swapSel | input | 1 | RGB order reversal select |
| red | input | 8 | Red component |
| green | input | 8 | Green component |
| blue | input | 8 | Blue component |
| vsync | input | 1 | Vertical sync |
| hsync | input | 1 | Horizontal sync |
| de | input | 1 | Data enable |
| serOut | output | 1 | Serial data bit |
| clkOut | output | 1 | Recreated pixel clock |
| outEn | output | 1 | Outputs valid |

## Verification
A pixClk edge passes through two sampling flops before it can capture the word. The bench therefore holds data and pixClk steady for three bit clocks after each change before it moves on. A frame is loaded on the bit-clock edge that ends position 29, so the bench always reads whole frames. It aligns each read on the sample where clkOut first shows high, then collects thirty consecutive samples. Enable and disable act one cycle after txEn changes, and the bench checks the outputs at the very next falling clock edge. All samples are taken on falling edges, half a cycle after the registers update.

// File: rtl/pix_ser_pkg.sv
package pix_ser_pkg;

  // Strobes from the sequencer to the datapath, valid for the current cycle.
  typedef struct packed {
    logic clear;    // wipe the shift register (transmitter disabled)
    logic load;     // move the next frame into the shift register
    logic shift;    // advance the shift register by one bit
    logic capture;  // latch the parallel input word
  } serStrobe_t;

endpackage

// File: rtl/pix_ser_ctrl.sv
module pix_ser_ctrl
  import pix_ser_pkg::*;
#(
  parameter int FRAME_W = 30
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEn,
  input  logic       pixClk,
  input  logic       edgeSel,
  output serStrobe_t strobe,
  output logic       clkOut,
  output logic       outEn
);

  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(FRAME_W / 2);

  logic [CNT_W-1:0] bitCnt;
  logic             outEnQ;
  logic             pixQ1;
  logic             pixQ2;
  logic             pixRise;
  logic             pixFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixQ1  <= 1'b0;
      pixQ2  <= 1'b0;
      outEnQ <= 1'b0;
      bitCnt <= '0;
    end else begin
      pixQ1 <= pixClk;
      pixQ2 <= pixQ1;
      if (!txEn) begin
        outEnQ <= 1'b0;
        bitCnt <= '0;
      end else if (!outEnQ) begin
        outEnQ <= 1'b1;
        bitCnt <= '0;
      end else if (bitCnt == LAST) begin
        bitCnt <= '0;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  assign pixRise = pixQ1 & ~pixQ2;
  assign pixFall = ~pixQ1 & pixQ2;

  always_comb begin
    strobe.clear   = ~txEn;
    strobe.load    = txEn & (~outEnQ | (bitCnt == LAST));
    strobe.shift   = txEn & outEnQ & (bitCnt != LAST);
    strobe.capture = edgeSel ? pixFall : pixRise;
  end

  assign clkOut = outEnQ & (bitCnt < HALF);
  assign outEn  = outEnQ;

  // R9: a low enable stops the stream one cycle later
  assert_disable_stops_R9: assert property (@(posedge clk) disable iff (!rstN)
    !txEn |=> (!outEnQ && bitCnt == '0));

  // R10: enabling from idle starts a frame at position 0
  assert_enable_starts_R10: assert property (@(posedge clk) disable iff (!rstN)
    (txEn && !outEnQ) |=> (outEnQ && bitCnt == '0));

  // R6: the recreated clock only rises at the frame boundary
  assert_clk_rise_at_boundary_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkOut) |-> (bitCnt == '0));

  // R6: the frame counter wraps after its last position
  assert_counter_wraps_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txEn && outEnQ && bitCnt == LAST) |=> (bitCnt == '0));

  // R5: at most one datapath action per cycle
  assert_strobe_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.clear, strobe.load, strobe.shift}));

endmodule

// File: rtl/pix_ser_path.sv
module pix_ser_path
  import pix_ser_pkg::*;
#(
  parameter int COLOR_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  serStrobe_t         strobe,
  input  logic               swapSel,
  input  logic [COLOR_W-1:0] red,
  input  logic [COLOR_W-1:0] green,
  input  logic [COLOR_W-1:0] blue,
  input  logic               vsync,
  input  logic               hsync,
  input  logic               de,
  output logic               serOut
);

  localparam int PAY_W   = 3 * COLOR_W + 3;
  localparam int FRAME_W = PAY_W + 3;

  logic [PAY_W-1:0]   mapped;
  logic [PAY_W-1:0]   holdWord;
  logic [FRAME_W-1:0] nextFrame;
  logic [FRAME_W-1:0] shReg;

  // Lane ordering: first colour goes out MSB-first normally, LSB-first when swapped.
  for (genvar i = 0; i < COLOR_W; i++) begin : g_lane
    assign mapped[i]             = swapSel ? blue[i]  : red[COLOR_W-1-i];
    assign mapped[COLOR_W+i]     = swapSel ? green[i] : green[COLOR_W-1-i];
    assign mapped[2*COLOR_W+i]   = swapSel ? red[i]   : blue[COLOR_W-1-i];
  end
  assign mapped[3*COLOR_W]   = vsync;
  assign mapped[3*COLOR_W+1] = hsync;
  assign mapped[3*COLOR_W+2] = de;

  // Odd parity over the payload, reserved pair forced low.
  assign nextFrame = {~^holdWord, 2'b00, holdWord};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdWord <= '0;
    end else if (strobe.capture) begin
      holdWord <= mapped;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (strobe.clear) begin
      shReg <= '0;
    end else if (strobe.load) begin
      shReg <= nextFrame;
    end else if (strobe.shift) begin
      shReg <= {1'b0, shReg[FRAME_W-1:1]};
    end
  end

  assign serOut = shReg[0];

  // R3: a freshly loaded frame has an odd count of ones
  assert_parity_odd_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> ($countones(shReg) % 2 == 1));

  // R4: reserved positions are zero in every loaded frame
  assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (shReg[PAY_W+1:PAY_W] == 2'b00));

  // R9: a cleared shift register drives the line low
  assert_clear_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> !serOut);

endmodule

// File: rtl/pix_ser_top.sv
module pix_ser_top
  import pix_ser_pkg::*;
#(
  parameter int COLOR_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txEn,
  input  logic               pixClk,
  input  logic               edgeSel,
  input  logic               swapSel,
  input  logic [COLOR_W-1:0] red,
  input  logic [COLOR_W-1:0] green,
  input  logic [COLOR_W-1:0] blue,
  input  logic               vsync,
  input  logic               hsync,
  input  logic               de,
  output logic               serOut,
  output logic               clkOut,
  output logic               outEn
);

  localparam int FRAME_W = 3 * COLOR_W + 6;

  serStrobe_t strobe;

  pix_ser_ctrl #(.FRAME_W(FRAME_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .txEn    (txEn),
    .pixClk  (pixClk),
    .edgeSel (edgeSel),
    .strobe  (strobe),
    .clkOut  (clkOut),
    .outEn   (outEn)
  );

  pix_ser_path #(.COLOR_W(COLOR_W)) path_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .swapSel (swapSel),
    .red     (red),
    .green   (green),
    .blue    (blue),
    .vsync   (vsync),
    .hsync   (hsync),
    .de      (de),
    .serOut  (serOut)
  );

endmodule

// File: tb/pix_ser_top_tb_top.sv
`timescale 1ns/1ps
module pix_ser_top_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txEn = 1'b0;
  logic       pixClk = 1'b0;
  logic       edgeSel = 1'b0;
  logic       swapSel = 1'b0;
  logic [7:0] red = '0;
  logic [7:0] green = '0;
  logic [7:0] blue = '0;
  logic       vsync = 1'b0;
  logic       hsync = 1'b0;
  logic       de = 1'b0;
  logic       serOut;
  logic       clkOut;
  logic       outEn;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pix_ser_top dut_i (
    .clk(clk), .rstN(rstN), .txEn(txEn), .pixClk(pixClk), .edgeSel(edgeSel),
    .swapSel(swapSel), .red(red), .green(green), .blue(blue), .vsync(vsync),
    .hsync(hsync), .de(de), .serOut(serOut), .clkOut(clkOut), .outEn(outEn)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [29:0] expFrame(input logic [7:0] r, input logic [7:0] g,
      input logic [7:0] b, input logic v, input logic h, input logic e, input logic sw);
    logic [29:0] f;
    f = '0;
    for (int i = 0; i < 8; i++) begin
      f[i]      = sw ? b[i] : r[7-i];
      f[8 + i]  = sw ? g[i] : g[7-i];
      f[16 + i] = sw ? r[i] : b[7-i];
    end
    f[24] = v;
    f[25] = h;
    f[26] = e;
    f[29] = ($countones(f[26:0]) % 2 == 0);
    return f;
  endfunction

  task automatic setWord(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                         input logic v, input logic h, input logic e);
    red = r; green = g; blue = b; vsync = v; hsync = h; de = e;
  endtask

  task automatic pixLevel(input logic lvl);
    @(negedge clk);
    pixClk = lvl;
    repeat (3) @(negedge clk);
  endtask

  // Capture on either edge setting: full high-low pulse, leaves pixClk low.
  task automatic pixPulse();
    pixLevel(1'b1);
    pixLevel(1'b0);
  endtask

  task automatic waitRise();
    logic prev;
    prev = clkOut;
    forever begin
      @(negedge clk);
      if (clkOut && !prev) break;
      prev = clkOut;
    end
  endtask

  task automatic readFrame(output logic [29:0] bits, output int highs, output bit shaped);
    waitRise();
    highs = 0;
    shaped = 1'b1;
    for (int k = 0; k < 30; k++) begin
      if (k > 0) @(negedge clk);
      bits[k] = serOut;
      if (clkOut) highs++;
      if (clkOut !== (k < 15)) shaped = 1'b0;
    end
  endtask

  task automatic testReset();
    check(outEn === 1'b0, "R11", "outEn in reset", 32'(outEn), 0);
    check(clkOut === 1'b0, "R11", "clkOut in reset", 32'(clkOut), 0);
    check(serOut === 1'b0, "R11", "serOut in reset", 32'(serOut), 0);
  endtask

  task automatic testFrame(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                           input logic v, input logic h, input logic e, input logic sw,
                           input string req);
    logic [29:0] got;
    logic [29:0] exp;
    int highs;
    bit shaped;
    @(negedge clk);
    swapSel = sw;
    setWord(r, g, b, v, h, e);
    pixPulse();
    exp = expFrame(r, g, b, v, h, e, sw);
    readFrame(got, highs, shaped);
    check(got === exp, req, "frame content", 32'(got), 32'(exp));
    check(got[29] === exp[29], "R3", "parity bit", 32'(got[29]), 32'(exp[29]));
    check(got[28:27] === 2'b00, "R4", "reserved bits", 32'(got[28:27]), 0);
    check(got[0] === exp[0], "R5", "bit 0 at clkOut rise", 32'(got[0]), 32'(exp[0]));
    check(highs == 15 && shaped, "R6", "clkOut high count", 32'(highs), 15);
  endtask

  task automatic testEdge();
    logic [29:0] got;
    int highs;
    bit shaped;
    swapSel = 1'b0;
    edgeSel = 1'b0;
    setWord(8'h11, 8'h22, 8'h33, 1'b1, 1'b0, 1'b1);
    pixLevel(1'b1);
    setWord(8'hEE, 8'hDD, 8'hCC, 1'b0, 1'b1, 1'b0);
    pixLevel(1'b0);
    readFrame(got, highs, shaped);
    check(got === expFrame(8'h11, 8'h22, 8'h33, 1'b1, 1'b0, 1'b1, 1'b0), "R7",
          "rising capture", 32'(got), 32'(expFrame(8'h11, 8'h22, 8'h33, 1'b1, 1'b0, 1'b1, 1'b0)));
    @(negedge clk);
    edgeSel = 1'b1;
    setWord(8'h5A, 8'h0F, 8'hF0, 1'b0, 1'b0, 1'b1);
    pixLevel(1'b1);
    setWord(8'hA5, 8'h3C, 8'hC3, 1'b1, 1'b1, 1'b0);
    pixLevel(1'b0);
    readFrame(got, highs, shaped);
    check(got === expFrame(8'hA5, 8'h3C, 8'hC3, 1'b1, 1'b1, 1'b0, 1'b0), "R7",
          "falling capture", 32'(got), 32'(expFrame(8'hA5, 8'h3C, 8'hC3, 1'b1, 1'b1, 1'b0, 1'b0)));
    @(negedge clk);
    edgeSel = 1'b0;
  endtask

  task automatic testLatency();
    logic [29:0] got;
    logic [29:0] expA;
    logic [29:0] expB;
    int highs;
    bit shaped;
    swapSel = 1'b0;
    setWord(8'h81, 8'h42, 8'h24, 1'b0, 1'b1, 1'b1);
    pixPulse();
    expA = expFrame(8'h81, 8'h42, 8'h24, 1'b0, 1'b1, 1'b1, 1'b0);
    expB = expFrame(8'h7E, 8'hBD, 8'hDB, 1'b1, 1'b0, 1'b0, 1'b0);
    waitRise();
    for (int k = 0; k < 30; k++) begin
      if (k > 0) @(negedge clk);
      got[k] = serOut;
      if (k == 5) begin
        setWord(8'h7E, 8'hBD, 8'hDB, 1'b1, 1'b0, 1'b0);
        pixClk = 1'b1;
      end
      if (k == 20) pixClk = 1'b0;
    end
    check(got === expA, "R8", "frame in flight kept", 32'(got), 32'(expA));
    readFrame(got, highs, shaped);
    check(got === expB, "R8", "next frame carries new word", 32'(got), 32'(expB));
  endtask

  task automatic testDisableEnable();
    bit quiet;
    logic [29:0] got;
    logic [29:0] exp;
    @(negedge clk);
    txEn = 1'b0;
    @(negedge clk);
    check(outEn === 1'b0 && clkOut === 1'b0 && serOut === 1'b0, "R9",
          "outputs after disable", 32'({outEn, clkOut, serOut}), 0);
    quiet = 1'b1;
    swapSel = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      setWord(8'(k * 37), 8'(k * 11), 8'hFF, 1'b1, 1'b1, 1'b1);
      if (k % 6 == 0) pixClk = ~pixClk;
      if (outEn !== 1'b0 || clkOut !== 1'b0 || serOut !== 1'b0) quiet = 1'b0;
    end
    check(quiet, "R9", "outputs stay low while disabled", 32'(quiet), 1);
    pixClk = 1'b0;
    setWord(8'hC6, 8'h39, 8'h9C, 1'b1, 1'b0, 1'b1);
    pixPulse();
    exp = expFrame(8'hC6, 8'h39, 8'h9C, 1'b1, 1'b0, 1'b1, 1'b1);
    txEn = 1'b1;
    @(negedge clk);
    check(outEn === 1'b1 && clkOut === 1'b1, "R10", "outEn and clkOut after enable",
          32'({outEn, clkOut}), 32'h3);
    for (int k = 0; k < 30; k++) begin
      if (k > 0) @(negedge clk);
      got[k] = serOut;
    end
    check(got === exp, "R10", "first frame after enable", 32'(got), 32'(exp));
    swapSel = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    txEn = 1'b1;
    repeat (2) @(negedge clk);
    testFrame(8'hA1, 8'h5C, 8'h37, 1'b1, 1'b0, 1'b1, 1'b0, "R1");
    testFrame(8'h01, 8'h80, 8'hF0, 1'b0, 1'b1, 1'b0, 1'b0, "R1");
    testFrame(8'hA1, 8'h5C, 8'h37, 1'b1, 1'b0, 1'b1, 1'b1, "R2");
    testFrame(8'h0E, 8'h71, 8'hC8, 1'b0, 1'b0, 1'b1, 1'b1, "R2");
    testFrame(8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
    testFrame(8'h00, 8'h00, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
    testFrame(8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0, "R3");
    testEdge();
    testLatency();
    testDisableEnable();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule